// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Multiplier

This block multiplies two 32-bit operands over several clock cycles. It takes 8 bits of the multiplier operand per iteration, least significant byte first. Each iteration adds one shifted partial product into a 64-bit running sum. The block stops as soon as the multiplier bits not yet consumed carry no further information, so an operation lasts 1 to 4 iterations depending on the data. Signed and unsigned modes use different rules to decide when to stop.

A single mode code selects one of six operations: a 32-bit product, a 32-bit product plus accumulator, a signed 64-bit product with or without a 64-bit accumulate, and an unsigned 64-bit product with or without a 64-bit accumulate. The caller pulses `start` while the block is idle. The block then holds `busy` for the iterations and pulses `done` for one cycle with the result. The `iters` output reports how many iterations were used, so a checker can verify both the value and the timing.

Top module: `emul_mult`

## Requirements
- R1: Mode code 0 returns the low 32 bits of op_a*op_b on result[31:0], with result[63:32] zero.
- R2: Mode code 1 returns the low 32 bits of op_a*op_b + acc_in[31:0] on result[31:0], with result[63:32] zero.
- R3: Mode code 2 returns the full 64-bit two's-complement product of op_a and op_b. Mode code 3 returns that product plus acc_in, modulo 2^64.
- R4: Mode code 4 returns the full 64-bit unsigned product of op_a and op_b. Mode code 5 returns that product plus acc_in, modulo 2^64.
- R5: In mode codes 0 to 3, the iteration count is set by op_b. It is 1 when op_b[31:8] is all zeros or all ones. Otherwise it is 2 when op_b[31:16] is all zeros or all ones. Otherwise it is 3 when op_b[31:24] is all zeros or all ones. In every other case it is 4.
- R6: In mode codes 4 and 5, the iteration count is 1, 2 or 3 only when op_b[31:8], op_b[31:16] or op_b[31:24] respectively is all zeros (smallest first). Otherwise it is 4, so op_b[31]=1 always gives 4.
- R7: The iters output equals the iteration count of the operation and is valid in the cycle in which done is high.
- R8: When start is sampled high while idle, busy is high from the next cycle for exactly as many cycles as the iteration count. done is then high for exactly one cycle with busy low, and result holds the value.
- R9: A start sampled while busy is high has no effect: no extra done pulse appears, and the running operation's result and count are unchanged.
- R10: After synchronous reset, busy, done, iters and result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 3 | Operation code (0..5, see R1-R4 list) |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier, consumed 8 bits per iteration |
| acc_in | input | 64 | Accumulator added in accumulate modes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Result, held until the next completion |
| iters | output | 3 | Iterations used by the last operation |

## Verification
The hardest case to reach is a signed stop where the unconsumed multiplier bits are all ones but the top bit of the last consumed byte is zero, as in 0xFFFFFF00 or 0xFFFF0012. There the negative weight of the discarded upper bits must be folded into the final partial product. The stimulus deliberately sweeps such operands, together with their all-zero and full-width counterparts, through every mode. The same operand therefore also shows the unsigned rule refusing to stop early. The ignored start is reached by raising start a second time, with different operands, in the cycle right after an accepted start, when busy is already high. The bench then watches several further cycles for a stray completion.

// File: rtl/emul_pkg.sv
package emul_pkg;

    localparam int unsigned OPW  = 32;
    localparam int unsigned DIGW = 8;
    localparam int unsigned PW   = 2 * OPW;
    localparam int unsigned NDIG = OPW / DIGW;
    localparam int unsigned CW   = $clog2(NDIG + 1);

    typedef enum logic [2:0] {
        OP_MUL32  = 3'd0,
        OP_MAC32  = 3'd1,
        OP_SMUL64 = 3'd2,
        OP_SMAC64 = 3'd3,
        OP_UMUL64 = 3'd4,
        OP_UMAC64 = 3'd5
    } op_e;

    typedef struct packed {
        logic [PW-1:0]  mcand;
        logic [OPW-1:0] mplier;
        logic           sgn;
        logic           narrow;
        logic [CW-1:0]  total;
    } job_t;

    function automatic logic op_is_unsigned(input logic [2:0] m);
        return m[2];
    endfunction

    function automatic logic op_is_narrow(input logic [2:0] m);
        return (m[2] == 1'b0) && (m[1] == 1'b0);
    endfunction

    function automatic logic op_is_accum(input logic [2:0] m);
        return m[0];
    endfunction

    // Smallest digit count after which the unconsumed bits are redundant.
    function automatic logic [CW-1:0] digits_needed(input logic [OPW-1:0] b,
                                                    input logic uns);
        logic [CW-1:0] n;
        logic [OPW-1:0] mask;
        n = CW'(NDIG);
        for (int k = NDIG - 1; k >= 1; k--) begin
            mask = {OPW{1'b1}} << (DIGW * k);
            if (((b & mask) == '0) || (!uns && ((b & mask) == mask)))
                n = CW'(k);
        end
        return n;
    endfunction

endpackage

// File: rtl/emul_len_detect.sv
module emul_len_detect
    import emul_pkg::*;
(
    input  logic [OPW-1:0] mplier,
    input  logic           uns,
    output logic [CW-1:0]  count
);
    always_comb count = digits_needed(mplier, uns);
endmodule

// File: rtl/emul_step.sv
module emul_step
    import emul_pkg::*;
(
    input  logic [PW-1:0]   mcand,
    input  logic [DIGW-1:0] digit,
    input  logic            fold,
    input  logic [CW-1:0]   pos,
    output logic [PW-1:0]   pp
);
    logic [PW-1:0] raw;
    logic [PW-1:0] adj;

    // fold turns the digit into digit - 2^DIGW, which carries the negative
    // weight of all discarded upper multiplier bits.
    always_comb begin
        raw = mcand * PW'(digit);
        adj = fold ? (raw - (mcand << DIGW)) : raw;
        pp  = adj << (DIGW * pos);
    end
endmodule

// File: rtl/emul_mult.sv
module emul_mult
    import emul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [OPW-1:0]    op_a,
    input  logic [OPW-1:0]    op_b,
    input  logic [PW-1:0]     acc_in,
    output logic              busy,
    output logic              done,
    output logic [PW-1:0]     result,
    output logic [CW-1:0]     iters
);

    job_t           job;
    job_t           job_new;
    logic [PW-1:0]  acc;
    logic [CW-1:0]  idx;
    logic [CW-1:0]  need;
    logic [PW-1:0]  pp;
    logic [PW-1:0]  sum;
    logic [DIGW-1:0] digit;
    logic           last;
    logic           fold;
    logic           accept;

    emul_len_detect u_len (
        .mplier (op_b),
        .uns    (op_is_unsigned(mode)),
        .count  (need)
    );

    always_comb begin
        job_new.mcand  = op_is_unsigned(mode) ? {{OPW{1'b0}}, op_a}
                                              : {{OPW{op_a[OPW-1]}}, op_a};
        job_new.mplier = op_b;
        job_new.sgn    = !op_is_unsigned(mode);
        job_new.narrow = op_is_narrow(mode);
        job_new.total  = need;
    end

    assign accept = start && !busy;
    assign last   = (idx == job.total - CW'(1));
    assign digit  = DIGW'(job.mplier >> (DIGW * idx));
    assign fold   = last && job.sgn && job.mplier[OPW-1];
    assign sum    = acc + pp;

    emul_step u_step (
        .mcand (job.mcand),
        .digit (digit),
        .fold  (fold),
        .pos   (idx),
        .pp    (pp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            job    <= '0;
            acc    <= '0;
            idx    <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            result <= '0;
            iters  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                job  <= job_new;
                acc  <= op_is_accum(mode) ? acc_in : '0;
                idx  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                acc <= sum;
                idx <= idx + CW'(1);
                if (last) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    iters  <= job.total;
                    result <= job.narrow ? {{OPW{1'b0}}, sum[OPW-1:0]} : sum;
                end
            end
        end
    end

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_iters_range_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (iters >= CW'(1) && iters <= CW'(NDIG)));

    assert_narrow_upper_R1: assert property (@(posedge clk) disable iff (rst)
        (done && job.narrow) |-> (result[PW-1:OPW] == '0));

    assert_ignore_start_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (job == $past(job)));

    assert_unsigned_top_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && op_is_unsigned(mode) && op_b[OPW-1]) |=> (job.total == CW'(NDIG)));

endmodule

// File: tb/sim_emul_mult.sv
module sim_emul_mult;
    import emul_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [63:0] acc_in = '0;
    logic        busy;
    logic        done;
    logic [63:0] result;
    logic [2:0]  iters;

    int compared = 0;
    int mismatched = 0;
    int busy_cnt = 0;

    typedef struct {
        logic [63:0] res;
        int          n;
        logic [2:0]  m;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    emul_mult u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .op_a(op_a),
        .op_b(op_b), .acc_in(acc_in), .busy(busy), .done(done),
        .result(result), .iters(iters)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic int ref_len(input logic [31:0] b, input bit uns);
        if (uns) begin
            if (b[31:8] == 24'h0) return 1;
            if (b[31:16] == 16'h0) return 2;
            if (b[31:24] == 8'h0) return 3;
            return 4;
        end
        if (b[31:8] == 24'h0 || b[31:8] == 24'hFFFFFF) return 1;
        if (b[31:16] == 16'h0 || b[31:16] == 16'hFFFF) return 2;
        if (b[31:24] == 8'h0 || b[31:24] == 8'hFF) return 3;
        return 4;
    endfunction

    function automatic logic [63:0] ref_res(input logic [2:0] m, input logic [31:0] a,
                                            input logic [31:0] b, input logic [63:0] c);
        logic signed [63:0] s;
        logic [63:0] u;
        logic [31:0] lo;
        s  = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        u  = {32'h0, a} * {32'h0, b};
        lo = a * b + c[31:0];
        case (m)
            3'd0: return {32'h0, u[31:0]};
            3'd1: return {32'h0, lo};
            3'd2: return s;
            3'd3: return s + c;
            3'd4: return u;
            default: return u + c;
        endcase
    endfunction

    function automatic string res_req(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Monitor: pops the scoreboard when a result appears.
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", {63'h0, done}, 64'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(result === e.res, res_req(e.m), "result", result, e.res);
                    check(int'(iters) == e.n, e.m[2] ? "R6/R7" : "R5/R7", "iters",
                          64'(iters), 64'(e.n));
                    check(busy_cnt == e.n, "R8", "busy cycles", 64'(busy_cnt), 64'(e.n));
                end
                busy_cnt = 0;
            end
        end
    end

    task automatic run_op(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
                          input logic [63:0] c, input bit inject);
        exp_t e;
        e.res = ref_res(m, a, b, c);
        e.n   = ref_len(b, m[2]);
        e.m   = m;
        sb.push_back(e);
        @(negedge clk);
        mode = m; op_a = a; op_b = b; acc_in = c; start = 1'b1;
        @(negedge clk);
        if (inject) begin
            mode = 3'd5; op_a = ~a; op_b = 32'h12345678; acc_in = ~c;
        end else begin
            start = 1'b0;
        end
        while (!done) begin
            @(negedge clk);
            start = 1'b0;
        end
        @(negedge clk);
        check(done == 1'b0, "R8", "done width", {63'h0, done}, 64'h0);
        if (inject) begin
            repeat (8) @(negedge clk);
            check(sb.size() == 0 && !busy, "R9", "no second op", 64'(sb.size()), 64'h0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] bvals [12];
        logic [31:0] avals [3];
        bvals = '{32'h0000007F, 32'hFFFFFF00, 32'h00001234, 32'hFFFF0012,
                  32'hFFFF8000, 32'h00ABCDEF, 32'hFF800000, 32'h12345678,
                  32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h00000000};
        avals = '{32'h00000003, 32'hDEADBEEF, 32'h80000001};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(busy == 0 && done == 0, "R10", "busy/done", {62'h0, busy, done}, 64'h0);
        check(result == 0, "R10", "result", result, 64'h0);
        check(iters == 0, "R10", "iters", 64'(iters), 64'h0);

        // R1 R2 R3 R4 R5 R6 R7 R8: sweep of modes and multiplier shapes
        for (int mi = 0; mi < 6; mi++)
            for (int bi = 0; bi < 12; bi++)
                for (int ai = 0; ai < 3; ai++)
                    run_op(3'(mi), avals[ai], bvals[bi],
                           64'hF0E1D2C3B4A59687 ^ 64'(bi * 977 + ai), 1'b0);

        // R9: start while busy is ignored
        run_op(3'd3, 32'hFFFFFFF9, 32'hFFFFFF00, 64'h1, 1'b1);
        run_op(3'd4, 32'h00010001, 32'h87654321, 64'h0, 1'b1);
        run_op(3'd0, 32'h0000000A, 32'h00000005, 64'h0, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule